// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Front End

This block is the register-facing half of a simple SCSI bus controller. A host reaches it through a byte-wide port. The port address is shifted right by a parameter, so the sixteen byte registers can sit on 1-, 2- or 4-byte strides. Each register has a read image and a write image, and the two are kept apart: some locations read back something other than what was last written, and one write address is an alias for another register.

Command bytes written to the command register are decoded at once. The decode updates the interrupt-reason, sequence-step, status and FIFO-flag read images. When a command asks for it, the decode also raises the single level interrupt line. Commands flagged as DMA copy the last written transfer-count bytes into the readable 16-bit counter, and that counter drives the DMA engine through `xfer_count`. A read of the interrupt-reason register acknowledges the interrupt as a side effect. The DMA engine reports that a count has run out through a pulse on `xfer_done`.

Top module: `scsi_ctl_frontend`

## Requirements
- R1: After reset the following read registers hold 0: status, interrupt reason, sequence step, FIFO flags, count low, count mid and command. The counter-high location (index 9) reads 0x04, config (index 8) reads 0x07, `irq` is low, `xfer_count` is 0 and `target_id` is 0.
- R2: The register index is `reg_addr >> ADDR_SHIFT` and the low `ADDR_SHIFT` address bits are ignored. The indices are: 0 count low, 1 count mid, 2 FIFO, 3 command, 4 status (read) / bus ID (write), 5 interrupt reason, 6 sequence step, 7 FIFO flags, 8 config, 9 counter high, and 10–15 scratch. A write to index 8 or 10–15 reads back unchanged. A write to index 9 leaves its read value unchanged.
- R3: `irq` equals status bit 7. It rises only in the cycle after a command write that raises it. It falls only after an acknowledging read of index 5 or a chip-reset command.
- R4: A read of index 5 with `wr_en` low returns the current reason byte. At the clock edge it then does four things: it clears the reason byte, clears status bit 4, sets the sequence step to 4 and lowers `irq`.
- R5: A command byte with bit 7 set loads the readable count low and mid bytes from the last bytes written to indices 0 and 1, and `xfer_count` is {mid, low}. Writes to indices 0 and 1 alone do not change the readable count.
- R6: Opcodes are bits 6:0 of the command byte. 0x00 changes nothing. 0x01 sets the reason to 0x08 (function complete) and clears the sequence step and FIFO flags; neither raises `irq`.
- R7: Opcode 0x03 sets the reason to 0x80 (bus reset seen). It raises `irq` only when config bit 6 (last written value) is 0.
- R8: Opcode 0x11 sets the reason to 0x08, ORs 0x07 (message-in phase) into status and raises `irq`. Opcode 0x12 sets the reason to 0x20 (disconnect), sets the sequence step to 0 and raises `irq`. Opcode 0x44 clears the reason byte and leaves `irq` unchanged.
- R9: Opcode 0x02 returns every read and write image to the R1 state.
- R10: Any other opcode changes only the command register (plus the R5 reload if bit 7 is set). It drives `illegal_cmd` high for exactly the one cycle after the write.
- R11: A write to index 4 sets the bus ID, and `target_id` is its low 3 bits. The status read value is unaffected.
- R12: A `xfer_done` pulse sets status bit 4 (count exhausted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4+ADDR_SHIFT | Byte address of the register access |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |
| xfer_done | input | 1 | Pulse from the DMA engine: transfer count exhausted |
| irq | output | 1 | Level interrupt request |
| illegal_cmd | output | 1 | One-cycle pulse after an unrecognised opcode |
| target_id | output | 3 | Selected target ID from the bus-ID register |
| xfer_count | output | 16 | Loaded transfer counter |

## Verification
A table of eight command bytes is run in sequence, and every command is followed by an acknowledging read. The table covers the no-op, flush, command-complete, message-accepted, enable-selection, bus-reset, unrecognised and DMA-flush opcodes. Because state carries over from one command to the next, the table can tell a reason or sequence value that was written apart from one that was left over from the previous command. It also shows that the message-in phase bits persist across acknowledges.

Directed cases then cover the remaining corners. Enable-selection is issued while an interrupt is pending, to show that it leaves the line up. Bus reset is issued with reporting suppressed. Count writes are made with and without a following DMA command. An unrecognised opcode is sent with bit 7 set, and the bus-ID alias is written. The final case shows that a chip-reset command undoes all of these.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;

    localparam int NREG  = 16;
    localparam int IDX_W = $clog2(NREG);

    typedef logic [IDX_W-1:0] idx_t;

    // register indices
    localparam idx_t IX_CNT_LO  = 4'd0;
    localparam idx_t IX_CNT_MID = 4'd1;
    localparam idx_t IX_FIFO    = 4'd2;
    localparam idx_t IX_CMD     = 4'd3;
    localparam idx_t IX_STAT    = 4'd4;
    localparam idx_t IX_INTR    = 4'd5;
    localparam idx_t IX_SEQ     = 4'd6;
    localparam idx_t IX_FLAGS   = 4'd7;
    localparam idx_t IX_CFG     = 4'd8;
    localparam idx_t IX_CNT_HI  = 4'd9;

    // status bits
    localparam int         ST_IRQ       = 7;
    localparam int         ST_CNT_ZERO  = 4;
    localparam logic [7:0] ST_MSG_IN    = 8'h07;

    // interrupt reason values
    localparam logic [7:0] RSN_FUNC_DONE = 8'h08;
    localparam logic [7:0] RSN_DISCON    = 8'h20;
    localparam logic [7:0] RSN_BUS_RST   = 8'h80;

    localparam logic [7:0] SEQ_DONE      = 8'd4;
    localparam logic [7:0] VARIANT_CODE  = 8'h04;
    localparam logic [7:0] CFG_RESET     = 8'h07;
    localparam int         CFG_NORPT_BIT = 6;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_FLUSH,
        OP_CHIP_RST,
        OP_BUS_RST,
        OP_CMD_DONE,
        OP_MSG_OK,
        OP_SEL_EN,
        OP_BAD
    } op_e;

    typedef logic [NREG-1:0][7:0] img_t;

    typedef struct packed {
        img_t rd;
        img_t wr;
        logic bad;
    } fe_state_t;

    function automatic img_t rd_reset_img();
        img_t m;
        m            = '0;
        m[IX_CNT_HI] = VARIANT_CODE;
        m[IX_CFG]    = CFG_RESET;
        return m;
    endfunction

endpackage

// File: rtl/scsi_fe_addr_dec.sv
module scsi_fe_addr_dec
    import scsi_fe_pkg::*;
#(
    parameter int ADDR_SHIFT = 2,
    localparam int AW = IDX_W + ADDR_SHIFT
) (
    input  logic [AW-1:0] addr,
    output idx_t          idx
);

    generate
        if (ADDR_SHIFT > 0) begin : g_strided
            logic unused_low;
            assign unused_low = ^addr[ADDR_SHIFT-1:0];
            assign idx        = addr[AW-1:ADDR_SHIFT];
        end else begin : g_packed
            assign idx = addr;
        end
    endgenerate

endmodule

// File: rtl/scsi_fe_op_dec.sv
module scsi_fe_op_dec
    import scsi_fe_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output op_e        op,
    output logic       dma
);

    assign dma = cmd_byte[7];

    always_comb begin
        unique case (cmd_byte[6:0])
            7'h00:   op = OP_NOP;
            7'h01:   op = OP_FLUSH;
            7'h02:   op = OP_CHIP_RST;
            7'h03:   op = OP_BUS_RST;
            7'h11:   op = OP_CMD_DONE;
            7'h12:   op = OP_MSG_OK;
            7'h44:   op = OP_SEL_EN;
            default: op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/scsi_fe_rd_mux.sv
module scsi_fe_rd_mux
    import scsi_fe_pkg::*;
(
    input  img_t       img,
    input  idx_t       idx,
    input  logic       en,
    output logic [7:0] data
);

    assign data = en ? img[idx] : 8'h00;

endmodule

// File: rtl/scsi_ctl_frontend.sv
module scsi_ctl_frontend
    import scsi_fe_pkg::*;
#(
    parameter int ADDR_SHIFT = 2,
    localparam int AW = IDX_W + ADDR_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          xfer_done,
    output logic          irq,
    output logic          illegal_cmd,
    output logic [2:0]    target_id,
    output logic [15:0]   xfer_count
);

    idx_t      idx;
    op_e       op;
    logic      op_dma;
    fe_state_t st_d, st_q;

    scsi_fe_addr_dec #(.ADDR_SHIFT(ADDR_SHIFT)) u_addr (
        .addr (reg_addr),
        .idx  (idx)
    );

    scsi_fe_op_dec u_op (
        .cmd_byte (wr_data),
        .op       (op),
        .dma      (op_dma)
    );

    scsi_fe_rd_mux u_rd (
        .img  (st_q.rd),
        .idx  (idx),
        .en   (rd_en),
        .data (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (wr_en) begin
            st_d.wr[idx] = wr_data;
            if (idx == IX_CMD) begin
                st_d.rd[IX_CMD] = wr_data;
                if (op_dma) begin
                    st_d.rd[IX_CNT_LO]  = st_q.wr[IX_CNT_LO];
                    st_d.rd[IX_CNT_MID] = st_q.wr[IX_CNT_MID];
                end
                unique case (op)
                    OP_NOP: ;
                    OP_FLUSH: begin
                        st_d.rd[IX_INTR]  = RSN_FUNC_DONE;
                        st_d.rd[IX_SEQ]   = 8'h00;
                        st_d.rd[IX_FLAGS] = 8'h00;
                    end
                    OP_CHIP_RST: begin
                        st_d.rd = rd_reset_img();
                        st_d.wr = '0;
                    end
                    OP_BUS_RST: begin
                        st_d.rd[IX_INTR] = RSN_BUS_RST;
                        if (!st_q.wr[IX_CFG][CFG_NORPT_BIT])
                            st_d.rd[IX_STAT][ST_IRQ] = 1'b1;
                    end
                    OP_CMD_DONE: begin
                        st_d.rd[IX_INTR]         = RSN_FUNC_DONE;
                        st_d.rd[IX_STAT]         = st_q.rd[IX_STAT] | ST_MSG_IN;
                        st_d.rd[IX_STAT][ST_IRQ] = 1'b1;
                    end
                    OP_MSG_OK: begin
                        st_d.rd[IX_INTR]         = RSN_DISCON;
                        st_d.rd[IX_SEQ]          = 8'h00;
                        st_d.rd[IX_STAT][ST_IRQ] = 1'b1;
                    end
                    OP_SEL_EN: begin
                        st_d.rd[IX_INTR] = 8'h00;
                    end
                    OP_BAD: begin
                        st_d.bad = 1'b1;
                    end
                endcase
            end else if (idx >= IX_CFG && idx != IX_CNT_HI) begin
                st_d.rd[idx] = wr_data;
            end
        end else if (rd_en && idx == IX_INTR) begin
            st_d.rd[IX_INTR]              = 8'h00;
            st_d.rd[IX_STAT][ST_CNT_ZERO] = 1'b0;
            st_d.rd[IX_STAT][ST_IRQ]      = 1'b0;
            st_d.rd[IX_SEQ]               = SEQ_DONE;
        end
        if (xfer_done)
            st_d.rd[IX_STAT][ST_CNT_ZERO] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rd  <= rd_reset_img();
            st_q.wr  <= '0;
            st_q.bad <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq         = st_q.rd[IX_STAT][ST_IRQ];
    assign illegal_cmd = st_q.bad;
    assign target_id   = st_q.wr[IX_STAT][2:0];
    assign xfer_count  = {st_q.rd[IX_CNT_MID], st_q.rd[IX_CNT_LO]};

endmodule

// File: rtl/scsi_fe_chk.sv
module scsi_fe_chk
    import scsi_fe_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input idx_t        idx,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic        rd_en,
    input logic        irq,
    input logic        illegal_cmd,
    input logic [15:0] xfer_count
);

    logic cmd_wr, ack_rd;
    assign cmd_wr = wr_en && idx == IX_CMD;
    assign ack_rd = rd_en && !wr_en && idx == IX_INTR;

    p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_wr));

    p_irq_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(cmd_wr) || $past(ack_rd)));

    p_ack_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> !irq);

    p_count_hold_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wr_data[7] && wr_data[6:0] != 7'h02) |=> $stable(xfer_count));

    p_count_hold_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx != IX_CMD) |=> $stable(xfer_count));

    p_illegal_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> $past(cmd_wr));

endmodule

bind scsi_ctl_frontend scsi_fe_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx         (idx),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .irq         (irq),
    .illegal_cmd (illegal_cmd),
    .xfer_count  (xfer_count)
);

// File: tb/tb_scsi_ctl_frontend.sv
module tb_scsi_ctl_frontend;
    import scsi_fe_pkg::*;

    localparam int SH = 2;
    localparam int AW = IDX_W + SH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          xfer_done = 1'b0;
    logic          irq, illegal_cmd;
    logic [2:0]    target_id;
    logic [15:0]   xfer_count;

    int   n_chk = 0;
    int   n_err = 0;
    logic done  = 1'b0;
    logic last_bad;
    logic [7:0] v;

    always #2 clk = ~clk;

    scsi_ctl_frontend #(.ADDR_SHIFT(SH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .xfer_done(xfer_done), .irq(irq), .illegal_cmd(illegal_cmd),
        .target_id(target_id), .xfer_count(xfer_count)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic       irq;
        logic       bad;
        logic [7:0] stat;
        logic [7:0] rsn;
        logic [7:0] seq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
        '{8'h01, 1'b0, 1'b0, 8'h00, 8'h08, 8'h00},
        '{8'h11, 1'b1, 1'b0, 8'h87, 8'h08, 8'h04},
        '{8'h12, 1'b1, 1'b0, 8'h87, 8'h20, 8'h00},
        '{8'h44, 1'b0, 1'b0, 8'h07, 8'h00, 8'h04},
        '{8'h03, 1'b1, 1'b0, 8'h87, 8'h80, 8'h04},
        '{8'h25, 1'b0, 1'b1, 8'h07, 8'h00, 8'h04},
        '{8'h81, 1'b0, 1'b0, 8'h07, 8'h08, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input idx_t i, input logic [7:0] d);
        @(negedge clk);
        reg_addr = {i, 2'b01};
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        last_bad = illegal_cmd;
    endtask

    task automatic rd(input idx_t i, output logic [7:0] q);
        @(negedge clk);
        reg_addr = {i, 2'b10};
        rd_en    = 1'b1;
        #1 q     = rd_data;
        @(negedge clk);
        rd_en    = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] c);
        case (c[6:0])
            7'h00, 7'h01: return "R6 table";
            7'h03:        return "R7 table";
            7'h11, 7'h12, 7'h44: return "R8 table";
            default:      return "R10 table";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 count", xfer_count, 0);
        chk("R1 target", target_id, 0);
        rd(IX_CNT_HI, v); chk("R1 variant", v, 8'h04);
        rd(IX_CFG, v);    chk("R1 config", v, 8'h07);
        rd(IX_STAT, v);   chk("R1 status", v, 8'h00);
        rd(IX_SEQ, v);    chk("R1 seq", v, 8'h00);

        // opcode table
        for (int k = 0; k < NV; k++) begin
            wr(IX_CMD, VECS[k].cmd);
            chk({tag_of(VECS[k].cmd), " illegal"}, last_bad, VECS[k].bad);
            chk({tag_of(VECS[k].cmd), " irq R3"}, irq, VECS[k].irq);
            rd(IX_STAT, v);  chk({tag_of(VECS[k].cmd), " status"}, v, VECS[k].stat);
            rd(IX_SEQ, v);   chk({tag_of(VECS[k].cmd), " seq"}, v, VECS[k].seq);
            rd(IX_FLAGS, v); chk({tag_of(VECS[k].cmd), " flags"}, v, 8'h00);
            rd(IX_INTR, v);  chk({tag_of(VECS[k].cmd), " reason R4"}, v, VECS[k].rsn);
            chk("R4 irq after ack", irq, 0);
        end

        // R12 and R4: count-zero set then cleared by ack
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        rd(IX_STAT, v); chk("R12 count zero set", v, 8'h17);
        rd(IX_INTR, v); chk("R4 ack reason", v, 8'h00);
        rd(IX_STAT, v); chk("R4 count zero cleared", v, 8'h07);
        rd(IX_SEQ, v);  chk("R4 seq done", v, 8'h04);

        // R8 enable selection keeps a pending interrupt
        wr(IX_CMD, 8'h11); chk("R8 cmd done irq", irq, 1);
        wr(IX_CMD, 8'h44); chk("R8 sel en keeps irq", irq, 1);
        rd(IX_INTR, v);    chk("R8 sel en reason", v, 8'h00);
        chk("R4 ack lowers", irq, 0);

        // R7 suppressed bus reset report
        wr(IX_CFG, 8'h47);
        rd(IX_CFG, v);     chk("R2 config readback", v, 8'h47);
        wr(IX_CMD, 8'h03); chk("R7 suppressed irq", irq, 0);
        rd(IX_STAT, v);    chk("R7 status", v, 8'h07);
        rd(IX_INTR, v);    chk("R7 reason", v, 8'h80);

        // R5 DMA reload
        wr(IX_CNT_LO, 8'h34);
        wr(IX_CNT_MID, 8'h12);
        chk("R5 no load on write", xfer_count, 16'h0000);
        rd(IX_CNT_LO, v);  chk("R5 low unchanged", v, 8'h00);
        wr(IX_CMD, 8'h80); chk("R5 reload", xfer_count, 16'h1234);
        rd(IX_CNT_LO, v);  chk("R5 low read", v, 8'h34);
        rd(IX_CNT_MID, v); chk("R5 mid read", v, 8'h12);
        wr(IX_CNT_LO, 8'h56);
        wr(IX_CMD, 8'h00); chk("R5 no reload without bit7", xfer_count, 16'h1234);
        wr(IX_CMD, 8'hA5);
        chk("R10 illegal with dma", last_bad, 1);
        chk("R5 reload on illegal dma", xfer_count, 16'h1256);
        @(negedge clk);    chk("R10 pulse one cycle", illegal_cmd, 0);
        rd(IX_CMD, v);     chk("R10 command image", v, 8'hA5);
        rd(IX_INTR, v);    chk("R10 reason untouched", v, 8'h00);

        // R11 bus ID alias
        wr(IX_STAT, 8'h2D); chk("R11 target", target_id, 3'd5);
        rd(IX_STAT, v);     chk("R11 status unaffected", v, 8'h07);

        // R2 scratch and counter-high
        wr(4'd12, 8'h5A);
        rd(4'd12, v);       chk("R2 scratch", v, 8'h5A);
        wr(IX_CNT_HI, 8'hFF);
        rd(IX_CNT_HI, v);   chk("R2 counter high ignores write", v, 8'h04);

        // R9 chip reset command
        wr(IX_CMD, 8'h02);
        chk("R9 irq", irq, 0);
        chk("R9 count", xfer_count, 0);
        chk("R9 target", target_id, 0);
        rd(IX_CFG, v);    chk("R9 config", v, 8'h07);
        rd(IX_CNT_HI, v); chk("R9 variant", v, 8'h04);
        rd(IX_STAT, v);   chk("R9 status", v, 8'h00);
        rd(IX_SEQ, v);    chk("R9 seq", v, 8'h00);
        rd(4'd12, v);     chk("R9 scratch", v, 8'h00);
        rd(IX_CMD, v);    chk("R9 command", v, 8'h00);
        wr(IX_CMD, 8'h03); chk("R9 config write image cleared R7", irq, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule